// File: doc/BRIEF.md
# Queue Condition Interrupt Controller

This block turns per-queue status flags into two level-sensitive interrupt lines: one line serves the lower half of the queues, the other serves the upper half. Each lower queue has a 3-bit trigger selector. It picks one of four status flags and can invert it. Each upper queue always fires when it is not nearly empty. The flags come from outside and are computed elsewhere.

Software programs the trigger selectors, an enable mask for each half and a sticky pending register for each half over a simple synchronous register bus. A pending bit latches when its queue is enabled and its trigger condition holds. The bit stays set until software writes a one to it, or until software disables that queue. Writing a zero to an enable bit that was set also clears the matching pending bit.

Register map (word addresses, default parameters): 0 to 3 hold the lower trigger selectors, 4 is the lower enable mask, 5 is the upper enable mask, 6 is the lower pending register and 7 is the upper pending register. Other addresses read as zero.

Top module: `qic_top`

## Requirements
- R1: After reset all selectors, enables and pending bits read as zero, and both interrupt lines are low.
- R2: Lower queue q keeps its selector in register q/8, bits 4*(q%8)+2 down to 4*(q%8). Bit 4*(q%8)+3 is reserved: writes to it are ignored and it reads as zero.
- R3: Selector bits 1:0 pick a flag of lo_flags[4q+3:4q], where bit 0 is empty, bit 1 nearly empty, bit 2 nearly full and bit 3 full. With selector bit 2 at zero, the condition is the picked flag itself.
- R4: With selector bit 2 at one, the condition is the inverse of the picked flag.
- R5: Upper queue u (queue 32+u) has the condition "hi_nearly_empty[u] is low", whatever the selector registers hold.
- R6: A pending bit sets on the clock edge after an edge at which its enable bit is already one and its condition is true. It never sets while its enable bit is zero.
- R7: A pending bit stays set after its condition goes false.
- R8: Writing to a pending register clears the bits written as one and leaves the bits written as zero unchanged.
- R9: When a clear and a set land on the same edge, the clear wins. If the condition still holds, the bit sets again on the next edge.
- R10: An enable write that turns a set enable bit to zero clears that queue's pending bit on the same edge.
- R11: irq_lo is high exactly when some lower pending bit is set, and irq_hi is high exactly when some upper pending bit is set.
- R12: The enable registers read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| lo_flags | input | 128 | Four status flags per lower queue |
| hi_nearly_empty | input | 32 | Nearly-empty flag per upper queue |
| irq_lo | output | 1 | Interrupt for the lower queues |
| irq_hi | output | 1 | Interrupt for the upper queues |

## Verification
The assertions check these properties on every cycle:
- A pending bit never sits under a cleared enable bit.
- A pending bit never drops without a bus write.
- An upper bit only sets after its queue was enabled and not nearly empty.
- A pending-register write leaves no written-one bit set.
- A rising interrupt line always traces back to an enabled, true condition.

Only the bench scenarios can show the rest:
- Each of the eight selector codes, together with its inversion, picks the right flag.
- The reserved nibble bit is dropped.
- A condition that still holds re-arms a bit one edge after its clear.

// File: rtl/qic_pkg.sv
package qic_pkg;

  localparam int SRC_W  = 3;  // selector width per lower queue
  localparam int FLAG_N = 4;  // status flags per lower queue

  typedef enum logic [1:0] {
    FLG_EMPTY      = 2'd0,
    FLG_NEAR_EMPTY = 2'd1,
    FLG_NEAR_FULL  = 2'd2,
    FLG_FULL       = 2'd3
  } flag_sel_e;

  // Trigger condition of a lower queue: picked flag, optionally inverted.
  function automatic logic src_condition(input logic [SRC_W-1:0] src,
                                         input logic [FLAG_N-1:0] flags);
    flag_sel_e pick;
    pick = flag_sel_e'(src[1:0]);
    return flags[pick] ^ src[2];
  endfunction

  // Upper queues use a fixed trigger: not nearly empty.
  function automatic logic hi_condition(input logic nearly_empty);
    return ~nearly_empty;
  endfunction

endpackage

// File: rtl/qic_src_bank.sv
module qic_src_bank #(
  parameter int HALF_Q = 32,
  parameter int DW     = 32,
  parameter int NIB    = 4,
  parameter int REGS   = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [REGS-1:0]             wr_stb,
  input  logic [DW-1:0]               wdata,
  input  logic [HALF_Q*qic_pkg::FLAG_N-1:0] flags,
  output logic [HALF_Q-1:0]           cond,
  output logic [REGS*DW-1:0]          rd_flat
);
  localparam int PER_REG = DW / NIB;
  localparam int PAD     = NIB - qic_pkg::SRC_W;

  logic [qic_pkg::SRC_W-1:0] src_q [HALF_Q];

  for (genvar q = 0; q < HALF_Q; q++) begin : g_q
    localparam int R = q / PER_REG;
    localparam int S = (q % PER_REG) * NIB;

    always_ff @(posedge clk) begin
      if (!rst_n)         src_q[q] <= '0;
      else if (wr_stb[R]) src_q[q] <= wdata[S +: qic_pkg::SRC_W];
    end

    assign cond[q] = qic_pkg::src_condition(src_q[q],
                       flags[q*qic_pkg::FLAG_N +: qic_pkg::FLAG_N]);
    assign rd_flat[R*DW + S +: NIB] = {{PAD{1'b0}}, src_q[q]};
  end

endmodule

// File: rtl/qic_pend_half.sv
module qic_pend_half #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_wr,
  input  logic         pend_wr,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] cond,
  output logic [N-1:0] en_q,
  output logic [N-1:0] pend_q,
  output logic [N-1:0] set_evt,
  output logic [N-1:0] clr_evt,
  output logic         irq
);
  function automatic logic [N-1:0] next_pend(input logic [N-1:0] pend,
                                             input logic [N-1:0] setv,
                                             input logic [N-1:0] clrv);
    return (pend | setv) & ~clrv;
  endfunction

  logic [N-1:0] w1c_mask, dis_mask;

  assign set_evt  = en_q & cond;
  assign w1c_mask = pend_wr ? wdata : '0;
  assign dis_mask = en_wr ? (en_q & ~wdata) : '0;
  assign clr_evt  = w1c_mask | dis_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      if (en_wr) en_q <= wdata;
      pend_q <= next_pend(pend_q, set_evt, clr_evt);
    end
  end

  assign irq = |pend_q;

endmodule

// File: rtl/qic_top.sv
module qic_top #(
  parameter int HALF_Q = 32,
  parameter int DW     = 32,
  parameter int AW     = 4,
  parameter int NIB    = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_wr,
  input  logic [AW-1:0]                bus_addr,
  input  logic [DW-1:0]                bus_wdata,
  output logic [DW-1:0]                bus_rdata,
  input  logic [HALF_Q*4-1:0]          lo_flags,
  input  logic [HALF_Q-1:0]            hi_nearly_empty,
  output logic                         irq_lo,
  output logic                         irq_hi
);
  localparam int SRC_REGS = HALF_Q * NIB / DW;
  localparam logic [AW-1:0] A_EN_LO   = AW'(SRC_REGS);
  localparam logic [AW-1:0] A_EN_HI   = AW'(SRC_REGS + 1);
  localparam logic [AW-1:0] A_PEND_LO = AW'(SRC_REGS + 2);
  localparam logic [AW-1:0] A_PEND_HI = AW'(SRC_REGS + 3);

  logic [SRC_REGS-1:0]    src_stb;
  logic [SRC_REGS*DW-1:0] src_rd;
  logic [HALF_Q-1:0]      cond_lo, cond_hi;
  logic [HALF_Q-1:0]      en_lo_w, en_hi_w, pend_lo_w, pend_hi_w;
  logic [HALF_Q-1:0]      set_lo_w, set_hi_w, clr_lo_w, clr_hi_w;

  for (genvar r = 0; r < SRC_REGS; r++) begin : g_stb
    assign src_stb[r] = bus_wr && (bus_addr == AW'(r));
  end

  for (genvar u = 0; u < HALF_Q; u++) begin : g_hi
    assign cond_hi[u] = qic_pkg::hi_condition(hi_nearly_empty[u]);
  end

  qic_src_bank #(.HALF_Q(HALF_Q), .DW(DW), .NIB(NIB), .REGS(SRC_REGS)) u_src (
    .clk(clk), .rst_n(rst_n), .wr_stb(src_stb), .wdata(bus_wdata),
    .flags(lo_flags), .cond(cond_lo), .rd_flat(src_rd)
  );

  qic_pend_half #(.N(HALF_Q)) u_lo (
    .clk(clk), .rst_n(rst_n),
    .en_wr(bus_wr && bus_addr == A_EN_LO),
    .pend_wr(bus_wr && bus_addr == A_PEND_LO),
    .wdata(bus_wdata), .cond(cond_lo),
    .en_q(en_lo_w), .pend_q(pend_lo_w), .set_evt(set_lo_w), .clr_evt(clr_lo_w),
    .irq(irq_lo)
  );

  qic_pend_half #(.N(HALF_Q)) u_hi (
    .clk(clk), .rst_n(rst_n),
    .en_wr(bus_wr && bus_addr == A_EN_HI),
    .pend_wr(bus_wr && bus_addr == A_PEND_HI),
    .wdata(bus_wdata), .cond(cond_hi),
    .en_q(en_hi_w), .pend_q(pend_hi_w), .set_evt(set_hi_w), .clr_evt(clr_hi_w),
    .irq(irq_hi)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr < AW'(SRC_REGS)) begin
      bus_rdata = src_rd[int'(bus_addr)*DW +: DW];
    end else begin
      case (bus_addr)
        A_EN_LO:   bus_rdata = en_lo_w;
        A_EN_HI:   bus_rdata = en_hi_w;
        A_PEND_LO: bus_rdata = pend_lo_w;
        A_PEND_HI: bus_rdata = pend_hi_w;
        default:   bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/qic_checker.sv
module qic_checker #(
  parameter int HALF_Q = 32,
  parameter int DW     = 32,
  parameter int AW     = 4,
  parameter logic [AW-1:0] PEND_LO_ADDR = 4'd6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [AW-1:0]     bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic [HALF_Q-1:0] hi_nearly_empty,
  input logic [HALF_Q-1:0] en_lo,
  input logic [HALF_Q-1:0] en_hi,
  input logic [HALF_Q-1:0] pend_lo,
  input logic [HALF_Q-1:0] pend_hi,
  input logic              irq_hi
);

  a_r10_lo_pend_within_en: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_lo & ~en_lo) == '0);

  a_r10_hi_pend_within_en: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_hi & ~en_hi) == '0);

  a_r7_lo_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_wr) |-> ($past(pend_lo) & ~pend_lo) == '0);

  a_r7_hi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_wr) |-> ($past(pend_hi) & ~pend_hi) == '0);

  a_r5_hi_set_needs_cond: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_hi & ~$past(pend_hi) & ~($past(en_hi) & ~$past(hi_nearly_empty))) == '0);

  a_r8_lo_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_wr) && $past(bus_addr) == PEND_LO_ADDR)
      |-> (pend_lo & $past(bus_wdata[HALF_Q-1:0])) == '0);

  a_r11_hi_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_hi) |-> ($past(en_hi) & ~$past(hi_nearly_empty)) != '0);

endmodule

bind qic_top qic_checker #(.HALF_Q(HALF_Q), .DW(DW), .AW(AW),
                           .PEND_LO_ADDR(A_PEND_LO)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .hi_nearly_empty(hi_nearly_empty),
  .en_lo(en_lo_w), .en_hi(en_hi_w), .pend_lo(pend_lo_w), .pend_hi(pend_hi_w),
  .irq_hi(irq_hi)
);

// File: tb/qic_top_bench.sv
module qic_top_bench;
  localparam logic [3:0] A_SRC0 = 4'd0, A_SRC1 = 4'd1, A_EN_LO = 4'd4,
                         A_EN_HI = 4'd5, A_PD_LO = 4'd6, A_PD_HI = 4'd7;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [127:0] lo_flags = '0;
  logic [31:0] hi_nearly_empty = '1;
  logic irq_lo, irq_hi;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  qic_top u_qic_top (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lo_flags(lo_flags),
    .hi_nearly_empty(hi_nearly_empty), .irq_lo(irq_lo), .irq_hi(irq_hi));

  // {expected, selector[2:0], flags[3:0]} for lower queue 5
  localparam logic [7:0] VEC [13] = '{
    8'b1_000_0001, 8'b0_000_1110, 8'b1_001_0010, 8'b0_001_0000,
    8'b1_010_0100, 8'b1_011_1000, 8'b0_011_0111, 8'b0_100_0001,
    8'b1_100_0000, 8'b0_101_0010, 8'b1_110_0000, 8'b0_111_1000,
    8'b1_111_0111 };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      peek(4'(a), d); chk("R1 register reset", d, 32'h0);
    end
    chk("R1 irq_lo reset", {31'b0, irq_lo}, 32'h0);
    chk("R1 irq_hi reset", {31'b0, irq_hi}, 32'h0);

    // R2 packing and reserved bits
    wr(A_SRC1, 32'hFFFF_FFFF);
    peek(A_SRC1, d); chk("R2 reserved bits dropped", d, 32'h7777_7777);
    wr(A_SRC1, 32'h0);

    // R3 / R4 table walk on lower queue 5 (register 0, bits 22:20)
    foreach (VEC[i]) begin
      wr(A_EN_LO, 32'h0);
      wr(A_SRC0, {9'b0, VEC[i][6:4], 20'b0});
      lo_flags[23:20] = VEC[i][3:0];
      wr(A_EN_LO, 32'h20);
      tick();
      peek(A_PD_LO, d);
      chk(VEC[i][6] ? "R4 inverted pick" : "R3 direct pick", d, {26'b0, VEC[i][7], 5'b0});
      chk("R11 irq_lo follows pending", {31'b0, irq_lo}, {31'b0, VEC[i][7]});
    end
    wr(A_EN_LO, 32'h0);
    lo_flags = '0;
    wr(A_SRC0, 32'h0);

    // R12 enable readback
    wr(A_EN_HI, 32'h0000_0100);
    peek(A_EN_HI, d); chk("R12 enable readback", d, 32'h0000_0100);

    // R5 / R6 upper queue 40 (bit 8), selector registers irrelevant
    wr(A_SRC1, 32'h7777_7777);
    tick(); tick();
    peek(A_PD_HI, d); chk("R6 no set while condition false", d, 32'h0);
    hi_nearly_empty[8] = 1'b0;
    hi_nearly_empty[9] = 1'b0;   // not enabled
    tick();
    peek(A_PD_HI, d); chk("R5 upper fixed trigger / R6 gating", d, 32'h0000_0100);
    chk("R11 irq_hi high", {31'b0, irq_hi}, 32'h1);

    // R7 sticky
    hi_nearly_empty[8] = 1'b1;
    tick(); tick();
    peek(A_PD_HI, d); chk("R7 pending sticky", d, 32'h0000_0100);

    // R8 write zeros keeps, write ones clears
    wr(A_PD_HI, 32'h0);
    peek(A_PD_HI, d); chk("R8 zero write no effect", d, 32'h0000_0100);
    wr(A_PD_HI, 32'h0000_0100);
    peek(A_PD_HI, d); chk("R8 write one clears", d, 32'h0);
    chk("R11 irq_hi low", {31'b0, irq_hi}, 32'h0);

    // R9 clear wins, re-arms next edge
    hi_nearly_empty[8] = 1'b0;
    tick();
    wr(A_PD_HI, 32'h0000_0100);
    peek(A_PD_HI, d); chk("R9 clear wins on its edge", d, 32'h0);
    tick();
    peek(A_PD_HI, d); chk("R9 re-set next edge", d, 32'h0000_0100);

    // R10 disable clears pending
    wr(A_EN_HI, 32'h0);
    peek(A_PD_HI, d); chk("R10 disable clears pending", d, 32'h0);
    tick(); tick();
    peek(A_PD_HI, d); chk("R10 stays clear while disabled", d, 32'h0);
    hi_nearly_empty = '1;

    // R11 OR of two lower queues (q5 reg0 src0, q13 reg1 nibble5 src0)
    lo_flags[20] = 1'b1; lo_flags[52] = 1'b1;
    wr(A_EN_LO, 32'h0000_2020);
    tick();
    lo_flags = '0;
    wr(A_PD_LO, 32'h0000_0020);
    peek(A_PD_LO, d); chk("R8 partial clear", d, 32'h0000_2000);
    chk("R11 irq_lo with one left", {31'b0, irq_lo}, 32'h1);
    wr(A_PD_LO, 32'h0000_2000);
    chk("R11 irq_lo drops", {31'b0, irq_lo}, 32'h0);

    done = 1'b1;
    summary();
  end
endmodule